// File: doc/BRIEF.md
# Clock Stop Monitor with CPU Clock Fallback

This block watches one of two system clocks, the main clock or the sub clock, from the domain of a slow internal reference clock. Both watched clocks come in as asynchronous inputs. Each one passes through a synchronizer and a toggle detector. A counter in the reference domain measures how long the selected clock goes without a transition. If that time reaches a programmed threshold, a sticky stop flag is set. The flag then drives either an interrupt request or a reset request, whichever is configured.

When a stop is detected, the block also overrides the CPU clock source select. It does this only when the failed clock is the one the CPU currently depends on. The CPU then moves to a safe internal clock and stays there until software clears the stop flag. At that point the select follows the requested source again.

Software brings the monitor up in three steps through a small register port. First it sets the enable register. Then it writes the mode and threshold registers. Finally it sets the run bit. The mode and threshold are frozen while the monitor runs.

Top module: `osd_monitor`

## Requirements
- R1: After reset, every register reads 0, `stop_flag`, `irq_req` and `rst_req` are 0, and `cpu_src_sel` equals `cpu_src_req`.
- R2: Register addresses are: 0 enable (bit0), 1 mode, 2 control, 3 threshold, 4 status. Writes to the mode, control and threshold registers are ignored while enable is 0. Writing 0 to enable also clears the run and interrupt-enable bits. Detection only happens while both enable and run are 1.
- R3: Mode bit0 selects the watched clock (0 main, 1 sub). A stop of the clock that is not selected never sets the flag.
- R4: While running, the flag is set after threshold+1 consecutive reference cycles in which no synchronized transition of the watched clock is seen. The threshold is a 12-bit field.
- R5: Any transition of the watched clock, rising or falling, restarts the count. A clock that toggles at least once every threshold+1 cycles never sets the flag.
- R6: The stop flag (status bit0) stays set until software writes 0 to status bit0. Writing 1 there has no effect.
- R7: Mode bit1 selects the action. When it is 1, `rst_req` equals the flag. When it is 0, `irq_req` equals the flag ANDed with control bit1 (interrupt enable). The interrupt-enable bit can be written while running, so a pending flag can be cleared before the interrupt is enabled.
- R8: Source codes are 0 main, 1 PLL from main, 2 sub, 3 high-speed internal, 4 high-speed internal divided by 8, 5 low-speed internal. A main-clock stop while the requested source is 0 or 1 forces the select to 4. A sub-clock stop while the requested source is 2 forces it to 5. In any other case the select is not overridden.
- R9: Once the flag is cleared, `cpu_src_sel` again equals `cpu_src_req`. It differs from `cpu_src_req` only while the flag is set.
- R10: Writes to the mode and threshold registers are ignored while the run bit (control bit0) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 12 | Register write data |
| rdata | output | 12 | Register read data for `addr` |
| main_clk_in | input | 1 | Main clock, asynchronous |
| sub_clk_in | input | 1 | Sub clock, asynchronous |
| cpu_src_req | input | 3 | CPU clock source chosen by software |
| cpu_src_sel | output | 3 | CPU clock source after fallback override |
| stop_flag | output | 1 | Sticky stop-detected flag |
| irq_req | output | 1 | Interrupt request |
| rst_req | output | 1 | Reset request |

## Verification
The hardest case to reach is a stop detected at the exact threshold boundary while the CPU request matches the failed clock, followed by recovery. To get there, the bench gates the toggling of each watched clock at chosen cycles while the monitor runs. It then changes the requested CPU source between runs, so that both fallback targets and the no-override case are reached. A behavioural model advances its own count and flag on every reference edge and is compared each cycle. This catches an off-by-one in the threshold or the synchronizer latency at the cycle where it occurs. Directed reads confirm that locked writes and writes while disabled leave the registers unchanged.

// File: rtl/osd_pkg.sv
package osd_pkg;

    typedef enum logic [2:0] {
        SRC_MAIN      = 3'd0,
        SRC_PLL_MAIN  = 3'd1,
        SRC_SUB       = 3'd2,
        SRC_HOCO      = 3'd3,
        SRC_HOCO_DIV8 = 3'd4,
        SRC_LOCO      = 3'd5
    } cpu_src_e;

    typedef enum logic [2:0] {
        ADDR_ENABLE = 3'd0,
        ADDR_MODE   = 3'd1,
        ADDR_CTRL   = 3'd2,
        ADDR_THRESH = 3'd3,
        ADDR_STATUS = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic act_reset;
        logic watch_sub;
    } mode_t;

    typedef struct packed {
        logic     valid;
        cpu_src_e src;
    } fallback_t;

    function automatic fallback_t pick_fallback(logic watch_sub, cpu_src_e cur);
        fallback_t f;
        f.valid = 1'b0;
        f.src   = cur;
        if (!watch_sub && (cur == SRC_MAIN || cur == SRC_PLL_MAIN)) begin
            f.valid = 1'b1;
            f.src   = SRC_HOCO_DIV8;
        end else if (watch_sub && cur == SRC_SUB) begin
            f.valid = 1'b1;
            f.src   = SRC_LOCO;
        end
        return f;
    endfunction

endpackage

// File: rtl/osd_edge_sync.sv
module osd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic toggle_seen
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[STAGES-1:0], async_in};
    end

    assign toggle_seen = pipe_q[STAGES] ^ pipe_q[STAGES-1];
endmodule

// File: rtl/osd_stop_timer.sv
module osd_stop_timer #(
    parameter int CMP_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             toggle_seen,
    input  logic [CMP_W-1:0] thresh,
    output logic             fire
);
    logic [CMP_W-1:0] cnt_q;
    logic             at_limit;

    assign at_limit = (cnt_q == thresh);
    assign fire     = active && !toggle_seen && at_limit;

    always_ff @(posedge clk) begin
        if (rst || !active)       cnt_q <= '0;
        else if (toggle_seen)     cnt_q <= '0;
        else if (at_limit)        cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

    p_cnt_le_thresh_r4: assert property (@(posedge clk) disable iff (rst)
        active |-> cnt_q <= thresh);

    p_toggle_restart_r5: assert property (@(posedge clk) disable iff (rst)
        active && toggle_seen |=> cnt_q == '0);
endmodule

// File: rtl/osd_regs.sv
module osd_regs
    import osd_pkg::*;
#(
    parameter int CMP_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [CMP_W-1:0] wdata,
    input  logic             stop_flag,
    output logic [CMP_W-1:0] rdata,
    output logic             clr_flag,
    output logic             en_q,
    output logic             run_q,
    output logic             irq_en_q,
    output mode_t            mode_q,
    output logic [CMP_W-1:0] thresh_q
);
    logic cfg_open;
    assign cfg_open = en_q && !run_q;
    assign clr_flag = wr_en && (addr == ADDR_STATUS) && !wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            run_q    <= 1'b0;
            irq_en_q <= 1'b0;
            mode_q   <= '0;
            thresh_q <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_ENABLE: begin
                    en_q <= wdata[0];
                    if (!wdata[0]) begin
                        run_q    <= 1'b0;
                        irq_en_q <= 1'b0;
                    end
                end
                ADDR_MODE: if (cfg_open) begin
                    mode_q.watch_sub <= wdata[0];
                    mode_q.act_reset <= wdata[1];
                end
                ADDR_CTRL: if (en_q) begin
                    run_q    <= wdata[0];
                    irq_en_q <= wdata[1];
                end
                ADDR_THRESH: if (cfg_open) thresh_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_ENABLE: rdata[0]   = en_q;
            ADDR_MODE:   rdata[1:0] = mode_q;
            ADDR_CTRL:   rdata[1:0] = {irq_en_q, run_q};
            ADDR_THRESH: rdata      = thresh_q;
            ADDR_STATUS: rdata[0]   = stop_flag;
            default:     rdata      = '0;
        endcase
    end

    p_cfg_locked_r10: assert property (@(posedge clk) disable iff (rst)
        run_q |=> $stable(mode_q) && $stable(thresh_q));

    p_run_needs_en_r2: assert property (@(posedge clk) disable iff (rst)
        run_q |-> en_q);
endmodule

// File: rtl/osd_monitor.sv
module osd_monitor
    import osd_pkg::*;
#(
    parameter int CMP_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [CMP_W-1:0] wdata,
    output logic [CMP_W-1:0] rdata,
    input  logic             main_clk_in,
    input  logic             sub_clk_in,
    input  logic [2:0]       cpu_src_req,
    output logic [2:0]       cpu_src_sel,
    output logic             stop_flag,
    output logic             irq_req,
    output logic             rst_req
);
    localparam int N_WATCH = 2;

    logic             clr_flag, en_q, run_q, irq_en_q, fire;
    mode_t            mode_q;
    logic [CMP_W-1:0] thresh_q;
    logic [N_WATCH-1:0] watch_in, watch_tog;
    logic             flag_q;
    fallback_t        ovr_q;

    assign watch_in = {sub_clk_in, main_clk_in};

    osd_regs #(.CMP_W(CMP_W)) i_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .stop_flag(flag_q), .rdata(rdata), .clr_flag(clr_flag),
        .en_q(en_q), .run_q(run_q), .irq_en_q(irq_en_q),
        .mode_q(mode_q), .thresh_q(thresh_q)
    );

    for (genvar gi = 0; gi < N_WATCH; gi++) begin : g_sync
        osd_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk(clk), .rst(rst), .async_in(watch_in[gi]),
            .toggle_seen(watch_tog[gi])
        );
    end

    osd_stop_timer #(.CMP_W(CMP_W)) i_timer (
        .clk(clk), .rst(rst), .active(en_q && run_q),
        .toggle_seen(watch_tog[mode_q.watch_sub]),
        .thresh(thresh_q), .fire(fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            ovr_q  <= '{valid: 1'b0, src: SRC_MAIN};
        end else begin
            if (fire)          flag_q <= 1'b1;
            else if (clr_flag) flag_q <= 1'b0;

            if (fire && !flag_q)
                ovr_q <= pick_fallback(mode_q.watch_sub, cpu_src_e'(cpu_src_req));
            else if (clr_flag && !fire)
                ovr_q.valid <= 1'b0;
        end
    end

    assign stop_flag   = flag_q;
    assign rst_req     = flag_q && mode_q.act_reset;
    assign irq_req     = flag_q && !mode_q.act_reset && irq_en_q;
    assign cpu_src_sel = ovr_q.valid ? ovr_q.src : cpu_src_req;

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        stop_flag && !(wr_en && addr == 3'd4 && !wdata[0]) |=> stop_flag);

    p_req_needs_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (rst_req || irq_req) |-> stop_flag);

    p_req_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(rst_req && irq_req));

    p_sel_override_r9: assert property (@(posedge clk) disable iff (rst)
        (cpu_src_sel != cpu_src_req) |-> stop_flag);

    p_fallback_code_r8: assert property (@(posedge clk) disable iff (rst)
        (cpu_src_sel != cpu_src_req) |-> (cpu_src_sel == 3'd4 || cpu_src_sel == 3'd5));
endmodule

// File: tb/test_osd_monitor.sv
`timescale 1ns/1ps
module test_osd_monitor;
    logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [11:0] wdata = 12'd0;
    wire  [11:0] rdata;
    logic        main_clk = 1'b0, sub_clk = 1'b0;
    logic [2:0]  cpu_src_req = 3'd0;
    wire  [2:0]  cpu_src_sel;
    wire         stop_flag, irq_req, rst_req;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    osd_monitor i_osd_monitor (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .main_clk_in(main_clk), .sub_clk_in(sub_clk),
        .cpu_src_req(cpu_src_req), .cpu_src_sel(cpu_src_sel),
        .stop_flag(stop_flag), .irq_req(irq_req), .rst_req(rst_req)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // watched clock generators
    bit main_on = 1, sub_on = 1;
    int main_ct = 0, sub_ct = 0;
    always @(posedge clk) begin
        #1;
        if (main_on) begin
            main_ct++;
            if (main_ct >= 3) begin main_ct = 0; main_clk = ~main_clk; end
        end
        if (sub_on) begin
            sub_ct++;
            if (sub_ct >= 5) begin sub_ct = 0; sub_clk = ~sub_clk; end
        end
    end

    // behavioural reference model
    bit m_en, m_run, m_irqen, m_sub, m_act_rst, m_flag, m_ovr_on;
    int m_thr, m_cnt, m_ovr;
    bit mh[3], sh[3];
    always @(posedge clk) begin
        bit act, tog, fire, clr, old_en, old_run;
        if (rst) begin
            m_en = 0; m_run = 0; m_irqen = 0; m_sub = 0; m_act_rst = 0;
            m_flag = 0; m_ovr_on = 0; m_thr = 0; m_cnt = 0; m_ovr = 0;
            foreach (mh[k]) begin mh[k] = 0; sh[k] = 0; end
        end else begin
            act  = m_en && m_run;
            tog  = m_sub ? (sh[1] != sh[2]) : (mh[1] != mh[2]);
            fire = 0;
            if (!act || tog) m_cnt = 0;
            else if (m_cnt == m_thr) begin fire = 1; m_cnt = 0; end
            else m_cnt++;
            clr = wr_en && addr == 3'd4 && wdata[0] == 1'b0;
            if (fire && !m_flag) begin
                m_ovr_on = 0;
                if (!m_sub && (cpu_src_req == 3'd0 || cpu_src_req == 3'd1)) begin m_ovr_on = 1; m_ovr = 4; end
                if (m_sub && cpu_src_req == 3'd2) begin m_ovr_on = 1; m_ovr = 5; end
            end else if (clr && !fire) m_ovr_on = 0;
            if (fire) m_flag = 1; else if (clr) m_flag = 0;
            old_en = m_en; old_run = m_run;
            if (wr_en) case (addr)
                3'd0: begin m_en = wdata[0]; if (!wdata[0]) begin m_run = 0; m_irqen = 0; end end
                3'd1: if (old_en && !old_run) begin m_sub = wdata[0]; m_act_rst = wdata[1]; end
                3'd2: if (old_en) begin m_run = wdata[0]; m_irqen = wdata[1]; end
                3'd3: if (old_en && !old_run) m_thr = int'(wdata);
                default: ;
            endcase
            mh[2] = mh[1]; mh[1] = mh[0]; mh[0] = main_clk;
            sh[2] = sh[1]; sh[1] = sh[0]; sh[0] = sub_clk;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R4 model stop_flag", int'(stop_flag), int'(m_flag));
            chk("R7 model rst_req", int'(rst_req), int'(m_flag && m_act_rst));
            chk("R7 model irq_req", int'(irq_req), int'(m_flag && !m_act_rst && m_irqen));
            chk("R8 model cpu_src_sel", int'(cpu_src_sel), m_ovr_on ? m_ovr : int'(cpu_src_req));
        end
    end

    task automatic wr(input logic [2:0] a, input int d);
        @(posedge clk); #1;
        wr_en = 1; addr = a; wdata = 12'(d);
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(posedge clk); #1;
        addr = a;
        @(negedge clk);
        v = int'(rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int v;
        idle(4);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 flag", int'(stop_flag), 0);
        chk("R1 rst_req", int'(rst_req), 0);
        chk("R1 sel", int'(cpu_src_sel), 0);
        for (int a = 0; a < 5; a++) begin rd(3'(a), v); chk("R1 reg", v, 0); end

        // R2 writes ignored while disabled
        wr(3'd1, 3); wr(3'd3, 9);
        rd(3'd1, v); chk("R2 mode while disabled", v, 0);
        rd(3'd3, v); chk("R2 thresh while disabled", v, 0);

        // bring up: enable, mode main+irq, threshold 10, run
        wr(3'd0, 1); wr(3'd1, 0); wr(3'd3, 10); wr(3'd2, 1);
        cpu_src_req = 3'd1;
        sub_on = 0;
        idle(100);
        chk("R5 running main clock, no flag", int'(stop_flag), 0);
        chk("R3 unwatched sub stop ignored", int'(stop_flag), 0);

        // R10 locked writes
        wr(3'd3, 3); rd(3'd3, v); chk("R10 thresh locked", v, 10);
        wr(3'd1, 1); rd(3'd1, v); chk("R10 mode locked", v, 0);

        // main stop while CPU on PLL-from-main
        main_on = 0;
        idle(30);
        chk("R4 flag after main stop", int'(stop_flag), 1);
        chk("R8 fallback to hoco/8", int'(cpu_src_sel), 4);
        chk("R7 irq masked", int'(irq_req), 0);
        wr(3'd2, 3);
        @(negedge clk); chk("R7 irq after enable", int'(irq_req), 1);
        wr(3'd4, 1);
        @(negedge clk); chk("R6 write 1 keeps flag", int'(stop_flag), 1);
        main_on = 1;
        idle(10);
        wr(3'd4, 0);
        @(negedge clk);
        chk("R6 flag cleared", int'(stop_flag), 0);
        chk("R9 select restored", int'(cpu_src_sel), 1);
        idle(40);
        chk("R5 no refire", int'(stop_flag), 0);

        // sub watch with reset action
        wr(3'd2, 0); wr(3'd1, 3); wr(3'd3, 7); wr(3'd2, 1);
        cpu_src_req = 3'd2;
        sub_on = 1;
        idle(20);
        main_on = 0;
        idle(30);
        chk("R3 unwatched main stop ignored", int'(stop_flag), 0);
        sub_on = 0;
        idle(30);
        chk("R4 flag after sub stop", int'(stop_flag), 1);
        chk("R7 rst_req", int'(rst_req), 1);
        chk("R7 irq off in reset mode", int'(irq_req), 0);
        chk("R8 fallback to loco", int'(cpu_src_sel), 5);
        sub_on = 1;
        idle(10);
        wr(3'd4, 0);
        @(negedge clk);
        chk("R9 select back to sub", int'(cpu_src_sel), 2);
        chk("R7 rst_req dropped", int'(rst_req), 0);

        // no override when CPU on unrelated source
        cpu_src_req = 3'd3;
        idle(5);
        sub_on = 0;
        idle(30);
        chk("R4 flag unrelated src", int'(stop_flag), 1);
        chk("R8 no override", int'(cpu_src_sel), 3);
        sub_on = 1;
        idle(10);
        wr(3'd4, 0);

        // disable clears run; detection stops
        wr(3'd0, 0);
        rd(3'd2, v); chk("R2 run cleared by disable", v, 0);
        sub_on = 0;
        idle(40);
        chk("R2 no detection while disabled", int'(stop_flag), 0);
        rd(3'd3, v); chk("R2 thresh kept", v, 7);

        idle(3);
        finish_run();
    end
endmodule